// File: doc/BRIEF.md
# Collision-Free Parallel Interleaver Address Generator

This block produces, one cycle at a time, the memory addresses used by a parallel soft-in soft-out decoder whose frame of N values is split into P = N/W windows of W values each. Storage is split into P single-port banks, and bank p holds the values of window p, at offsets 0 to W-1. On every active cycle the block hands out one (bank, offset) pair per window. The P banks named in any one cycle are all different, so each bank serves exactly one access per cycle and no window ever waits.

Addresses come from a small amount of arithmetic (a cycle counter, additions and modulo operations), not from a stored permutation table. In linear order, window p at step t uses bank p, offset t. In interleaved order the bank is rotated by the step number: window p uses bank (ROW_MULT*p + t) mod P. The offset is a per-step column reordering: (COL_MULT*t + COL_OFS) mod W. ROW_MULT selects a reordering of the rows and COL_MULT/COL_OFS a reordering within each row. With all three set to the identity (1, 1, 0), the result is the plain progressive cyclic-shift pattern.

The write-back side repeats the read addresses after a fixed pipeline latency. Results of a linear pass go back to the linear positions. Results of an interleaved pass return to the very locations their inputs came from, which yields the deinterleaved order for free and keeps it collision-free.

Top module: `ilv_addr_gen`

## Requirements
- R1: After reset, and whenever no pass is active, rd_valid, wr_valid and done are 0 and all rd_bank/rd_off/wr_bank/wr_off fields are 0.
- R2: In every cycle with rd_valid=1, the P bank fields of rd_bank (window p in bits [p*BW +: BW]) are pairwise different, in both orders.
- R3: Linear order (mode_ilv=0 at start): at step t, window p reads bank p, offset t.
- R4: Interleaved order (mode_ilv=1 at start): at step t, window p reads bank (ROW_MULT*p + t) mod P and offset (COL_MULT*t + COL_OFS) mod W, so a window's bank advances by one (mod P) per step.
- R5: Over one pass, the P*W (bank, offset) pairs produced are exactly the N locations bank*W+offset = 0..N-1, each once.
- R6: A start accepted at a clock edge makes rd_valid 1 for exactly W consecutive cycles starting at the next cycle, with step t = 0..W-1; done is 1 for exactly the one cycle after the last step.
- R7: A start while a pass is running is ignored: the running pass and its order are unchanged and no extra pass follows.
- R8: wr_valid, wr_bank and wr_off equal rd_valid, rd_bank and rd_off from LAT cycles earlier, so interleaved reads are written back in deinterleaved order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Pulse to begin a pass (ignored while busy) |
| mode_ilv | input | 1 | Order for the pass: 0 linear, 1 interleaved; sampled with start |
| rd_valid | output | 1 | Read addresses valid this cycle |
| rd_bank | output | P*BW | Bank index per window, window p in [p*BW +: BW] |
| rd_off | output | P*OW | Offset per window, window p in [p*OW +: OW] |
| wr_valid | output | 1 | Write-back addresses valid this cycle |
| wr_bank | output | P*BW | Write-back bank per window |
| wr_off | output | P*OW | Write-back offset per window |
| done | output | 1 | One-cycle pulse after the final read step |

## Verification
The bench runs N=16, W=4 with non-identity row and column multipliers and a column offset, so that it tries the linear order, the interleaved order and a second start fired in the middle of a pass. Linear passes show that the counter and gating are right. Interleaved passes set the rotation and column arithmetic apart from the plain order, and a per-pass seen-table shows any lost or duplicated location. The write-back stream is compared against the read stream three cycles earlier, and the mid-pass start must change neither the addresses nor the pass count.

// File: rtl/ilv_pkg.sv
package ilv_pkg;
  // Interleaved-order bank for window p at step t: row reorder then rotation.
  function automatic int unsigned ilv_bank(input int unsigned p, input int unsigned t,
                                           input int unsigned nrow, input int unsigned rmul);
    return ((rmul * p) % nrow + t) % nrow;
  endfunction

  // Interleaved-order offset at step t: column reorder inside each row.
  function automatic int unsigned ilv_off(input int unsigned t, input int unsigned ncol,
                                          input int unsigned cmul, input int unsigned cofs);
    return (cmul * t + cofs) % ncol;
  endfunction
endpackage

// File: rtl/ilv_seq.sv
module ilv_seq #(
  parameter int unsigned W = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic                 mode_in,
  output logic                 busy,
  output logic [$clog2(W)-1:0] step,
  output logic                 mode_q,
  output logic                 done
);
  localparam int unsigned CW = $clog2(W);
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  logic accept;
  logic last_step;
  assign accept    = start && !busy;
  assign last_step = busy && (step == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      step   <= '0;
      mode_q <= 1'b0;
      done   <= 1'b0;
    end else begin
      done <= last_step;
      if (accept) begin
        busy   <= 1'b1;
        step   <= '0;
        mode_q <= mode_in;
      end else if (last_step) begin
        busy <= 1'b0;
        step <= '0;
      end else if (busy) begin
        step <= step + 1'b1;
      end
    end
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy && $past(busy)) else $error("done without a finished pass"); // R6

  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    busy && start && !last_step |=> busy && step == $past(step) + 1'b1 && mode_q == $past(mode_q))
    else $error("start disturbed a running pass"); // R7
endmodule

// File: rtl/ilv_lane.sv
module ilv_lane #(
  parameter int unsigned P       = 4,
  parameter int unsigned W       = 4,
  parameter int unsigned IDX     = 0,
  parameter int unsigned ROW_MUL = 1,
  parameter int unsigned COL_MUL = 1,
  parameter int unsigned COL_OFS = 0
) (
  input  logic [$clog2(W)-1:0] step,
  input  logic                 mode_ilv,
  input  logic                 active,
  output logic [$clog2(P)-1:0] bank,
  output logic [$clog2(W)-1:0] off
);
  localparam int unsigned BW = $clog2(P);
  localparam int unsigned OW = $clog2(W);

  logic [BW-1:0] bank_ilv;
  logic [OW-1:0] off_ilv;

  always_comb begin
    bank_ilv = BW'(ilv_pkg::ilv_bank(IDX, 32'(step), P, ROW_MUL));
    off_ilv  = OW'(ilv_pkg::ilv_off(32'(step), W, COL_MUL, COL_OFS));
    if (!active) begin
      bank = '0;
      off  = '0;
    end else if (mode_ilv) begin
      bank = bank_ilv;
      off  = off_ilv;
    end else begin
      bank = BW'(IDX);
      off  = step;
    end
  end
endmodule

// File: rtl/ilv_wdelay.sv
module ilv_wdelay #(
  parameter int unsigned WIDTH = 8,
  parameter int unsigned LAT   = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [WIDTH-1:0] stage [LAT];

  generate
    for (genvar i = 0; i < LAT; i++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage[i] <= '0;
        else        stage[i] <= (i == 0) ? din : stage[(i == 0) ? 0 : i - 1];
      end
    end
  endgenerate

  assign dout = stage[LAT-1];
endmodule

// File: rtl/ilv_addr_gen.sv
module ilv_addr_gen #(
  parameter int unsigned N       = 16,
  parameter int unsigned W       = 4,
  parameter int unsigned ROW_MUL = 3,
  parameter int unsigned COL_MUL = 3,
  parameter int unsigned COL_OFS = 1,
  parameter int unsigned LAT     = 3,
  localparam int unsigned P      = N / W,
  localparam int unsigned BW     = $clog2(P),
  localparam int unsigned OW     = $clog2(W)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic            mode_ilv,
  output logic            rd_valid,
  output logic [P*BW-1:0] rd_bank,
  output logic [P*OW-1:0] rd_off,
  output logic            wr_valid,
  output logic [P*BW-1:0] wr_bank,
  output logic [P*OW-1:0] wr_off,
  output logic            done
);
  localparam int unsigned DW = 1 + P * BW + P * OW;

  logic          busy;
  logic [OW-1:0] step;
  logic          mode_q;
  logic [BW-1:0] lane_bank [P];
  logic [OW-1:0] lane_off  [P];
  logic [P-1:0]  bank_hits;
  logic [DW-1:0] wr_bus;

  ilv_seq #(.W(W)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .mode_in(mode_ilv),
    .busy(busy), .step(step), .mode_q(mode_q), .done(done)
  );

  generate
    for (genvar p = 0; p < P; p++) begin : g_lane
      ilv_lane #(
        .P(P), .W(W), .IDX(p), .ROW_MUL(ROW_MUL), .COL_MUL(COL_MUL), .COL_OFS(COL_OFS)
      ) u_lane (
        .step(step), .mode_ilv(mode_q), .active(busy),
        .bank(lane_bank[p]), .off(lane_off[p])
      );
      assign rd_bank[p*BW +: BW] = lane_bank[p];
      assign rd_off[p*OW +: OW]  = lane_off[p];

      AST_LINEAR_BANK: assert property (@(posedge clk) disable iff (!rst_n)
        busy && !mode_q |-> lane_bank[p] == BW'(p) && lane_off[p] == step)
        else $error("linear address wrong"); // R3

      AST_ROTATE: assert property (@(posedge clk) disable iff (!rst_n)
        busy && mode_q && step != OW'(W - 1) |=>
          lane_bank[p] == BW'((32'($past(lane_bank[p])) + 1) % P))
        else $error("interleaved bank did not rotate"); // R4
    end
  endgenerate

  assign rd_valid = busy;

  always_comb begin
    bank_hits = '0;
    for (int p = 0; p < P; p++) bank_hits[lane_bank[p]] = 1'b1;
  end

  AST_BANKS_DISTINCT: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> &bank_hits) else $error("bank collision"); // R2

  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_valid |-> rd_bank == '0 && rd_off == '0) else $error("idle address not zero"); // R1

  ilv_wdelay #(.WIDTH(DW), .LAT(LAT)) u_wdelay (
    .clk(clk), .rst_n(rst_n),
    .din({rd_valid, rd_bank, rd_off}),
    .dout(wr_bus)
  );

  assign {wr_valid, wr_bank, wr_off} = wr_bus;
endmodule

// File: tb/ilv_addr_gen_bench.sv
module ilv_addr_gen_bench;
  localparam int N = 16, W = 4, P = 4, BW = 2, OW = 2;
  localparam int RM = 3, CM = 3, CO = 1, LAT = 3;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, mode_ilv = 1'b0;
  logic rd_valid, wr_valid, done;
  logic [P*BW-1:0] rd_bank, wr_bank;
  logic [P*OW-1:0] rd_off, wr_off;

  int errors = 0, checks = 0, passes_seen = 0;

  ilv_addr_gen #(.N(N), .W(W), .ROW_MUL(RM), .COL_MUL(CM), .COL_OFS(CO), .LAT(LAT)) u_ilv_addr_gen (
    .clk(clk), .rst_n(rst_n), .start(start), .mode_ilv(mode_ilv),
    .rd_valid(rd_valid), .rd_bank(rd_bank), .rd_off(rd_off),
    .wr_valid(wr_valid), .wr_bank(wr_bank), .wr_off(wr_off), .done(done)
  );

  always #4 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Expected location (bank*W + offset) for window p at step t; the source row
  // is found by walking the row map, the column by stepping the column map.
  function automatic int exp_loc(input bit ilv, input int p, input int t);
    int row, col;
    if (!ilv) return p * W + t;
    row = 0;
    for (int k = 0; k < p; k++) row = (row + RM) % P;
    row = (row + t) % P;
    col = CO % W;
    for (int k = 0; k < t; k++) col = (col + CM) % W;
    return row * W + col;
  endfunction

  task automatic run_pass(input bit ilv, input bit inject);
    int seen [N];
    foreach (seen[i]) seen[i] = 0;
    start = 1'b1; mode_ilv = ilv;
    @(negedge clk);
    start = 1'b0;
    for (int s = 0; s <= W + LAT; s++) begin
      if (s < W) begin
        int used;
        chk(rd_valid == 1'b1, "R6 rd_valid during pass", rd_valid, 1);
        used = 0;
        for (int p = 0; p < P; p++) begin
          int b, o;
          b = int'(rd_bank[p*BW +: BW]);
          o = int'(rd_off[p*OW +: OW]);
          chk(b * W + o == exp_loc(ilv, p, s), ilv ? "R4 interleaved address" : "R3 linear address",
              b * W + o, exp_loc(ilv, p, s));
          seen[b * W + o]++;
          used |= (1 << b);
        end
        chk(used == (1 << P) - 1, "R2 distinct banks", used, (1 << P) - 1);
      end
      if (s >= LAT && s - LAT < W) begin
        chk(wr_valid == 1'b1, "R8 wr_valid", wr_valid, 1);
        for (int p = 0; p < P; p++)
          chk(int'(wr_bank[p*BW +: BW]) * W + int'(wr_off[p*OW +: OW]) == exp_loc(ilv, p, s - LAT),
              "R8 write-back address",
              int'(wr_bank[p*BW +: BW]) * W + int'(wr_off[p*OW +: OW]), exp_loc(ilv, p, s - LAT));
      end
      if (s == W) begin
        chk(done == 1'b1, "R6 done after last step", done, 1);
        chk(rd_valid == 1'b0, "R6 rd_valid ends", rd_valid, 0);
        chk(rd_bank == '0 && rd_off == '0, "R1 idle outputs zero", int'(rd_bank), 0);
      end
      if (s == W + 1) chk(done == 1'b0, "R6 done one cycle", done, 0);
      if (inject && s == 1) begin start = 1'b1; mode_ilv = !ilv; end
      if (inject && s == 2) start = 1'b0;
      @(negedge clk);
    end
    for (int i = 0; i < N; i++) chk(seen[i] == 1, "R5 each location once", seen[i], 1);
    for (int k = 0; k < 3; k++) begin
      chk(rd_valid == 1'b0 && wr_valid == 1'b0, "R7 no extra pass", rd_valid, 0);
      @(negedge clk);
    end
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(rd_valid == 1'b0 && wr_valid == 1'b0, "R1 valids low in reset", rd_valid, 0);
    chk(done == 1'b0, "R1 done low in reset", done, 0);
    chk(rd_bank == '0 && rd_off == '0 && wr_bank == '0 && wr_off == '0, "R1 zero addresses",
        int'(rd_bank), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(rd_valid == 1'b0, "R1 idle after reset", rd_valid, 0);
    run_pass(1'b0, 1'b0);
    run_pass(1'b1, 1'b0);
    run_pass(1'b1, 1'b1);   // R7: start with flipped order mid-pass
    run_pass(1'b0, 1'b1);   // R7: same in linear order
    run_pass(1'b1, 1'b0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule